// File: doc/BRIEF.md
# Adaptive One-or-Two-Cycle Hold Controller

This controller sits beside a bypassing multiplier and decides, for every operand that arrives with a valid strobe, whether the multiply can finish in a single cycle or needs the input registers held for one more cycle. It counts the zero bits of the operand that controls bypassing. An operand with enough zeros is treated as fast. Any other operand makes the controller drop an active-low gating output for exactly one cycle, so the input registers keep their contents while the long path settles.

A timing-error flag from the result register reports a one-cycle operation that did not in fact finish. When it arrives, the controller raises a re-execute request and holds the inputs for one extra cycle. Errors are counted over a window made up of a fixed number of accepted operations. If the errors within one window reach a limit, a sticky aged flag sets. From then on, an operand must have one more zero than before to count as fast.

Top module: `adaptive_hold_judge`

## Requirements
- R1: After reset, `gate_n` is 1, `aged` is 0 and `reexec` is 0.
- R2: While `aged` is 0, an operand accepted with more than THRESH zero bits leaves `gate_n` at 1, which is a one-cycle operation. With the defaults (16 bits, THRESH 8), this applies to 9 or more zeros.
- R3: An operand that is accepted but not judged fast drives `gate_n` to 0 in the cycle after the accepting edge. On the following edge `gate_n` returns to 1.
- R4: While the inputs are held, `op_valid` is ignored. When the hold releases, a slow operand presented during the held cycle causes no further hold.
- R5: When `timing_err` is 1 in a non-held cycle, the next cycle has `reexec` = 1 and `gate_n` = 0, lasting one cycle. The error takes priority over an `op_valid` presented in the same cycle.
- R6: During a re-execute cycle, `op_valid` and the zero-count judgement are ignored.
- R7: An accepted operand whose zero count is at or below the active threshold is held. With defaults and `aged` = 0, 8 zeros are held.
- R8: `aged` sets on the edge that records the ERR_LIMIT-th error (default 3) within one window. It stays set until reset.
- R9: Once `aged` is 1, the threshold becomes THRESH+1. With defaults, 9 zeros are held and 10 zeros run in one cycle.
- R10: A window closes on the edge that accepts its WINDOW-th operation (default 8). Both the operation and error counts then restart at zero. Re-executions are not counted as operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A new operand is presented |
| op_data | input | OP_W | Operand whose zero bits are counted |
| timing_err | input | 1 | Result register reports a late one-cycle result |
| gate_n | output | 1 | Active-low input-register enable; 0 holds the inputs |
| aged | output | 1 | Sticky flag: the error limit was reached in one window |
| reexec | output | 1 | Request to re-execute the current operation |

## Verification
The assertions take for granted that `timing_err` refers to the operation that has just completed. They also assume that anything presented during a held cycle, whether a strobe or an error, is meant to be dropped. For that reason, they only check the busy cycle for its fixed one-cycle length and its release. The stimulus raises `timing_err` only in cycles that are not held. It deliberately drives `op_valid` with slow operands during held and re-execute cycles, so the ignore rules are seen at `gate_n`.

// File: rtl/adaptive_hold_judge.sv
module adaptive_hold_judge #(
  parameter int OP_W      = 16,
  parameter int THRESH    = 8,
  parameter int WINDOW    = 8,
  parameter int ERR_LIMIT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_data,
  input  logic            timing_err,
  output logic            gate_n,
  output logic            aged,
  output logic            reexec
);

  localparam int ZC_W = $clog2(OP_W + 1);
  localparam int OC_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam int EC_W = $clog2(ERR_LIMIT + 1);
  localparam logic [ZC_W-1:0] THR_LO = ZC_W'(THRESH);
  localparam logic [ZC_W-1:0] THR_HI = ZC_W'(THRESH + 1);

  logic            busy;
  logic [ZC_W-1:0] zcount;
  logic [OC_W-1:0] op_cnt;
  logic [EC_W-1:0] err_cnt;
  logic            fast, accept, err_hit, win_end;

  always_comb begin
    zcount = '0;
    for (int i = 0; i < OP_W; i++)
      zcount = zcount + ZC_W'(~op_data[i]);
  end

  assign fast    = aged ? (zcount > THR_HI) : (zcount > THR_LO);
  assign err_hit = !busy && timing_err;
  assign accept  = !busy && op_valid && !timing_err;
  assign win_end = accept && (op_cnt == OC_W'(WINDOW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      gate_n <= 1'b1;
      reexec <= 1'b0;
    end else begin
      reexec <= err_hit;
      if (busy) begin
        busy   <= 1'b0;
        gate_n <= 1'b1;
      end else if (err_hit || (accept && !fast)) begin
        busy   <= 1'b1;
        gate_n <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_cnt  <= '0;
      err_cnt <= '0;
      aged    <= 1'b0;
    end else begin
      if (win_end) begin
        op_cnt  <= '0;
        err_cnt <= '0;
      end else if (accept) begin
        op_cnt <= op_cnt + 1'b1;
      end
      if (err_hit) begin
        if (err_cnt != EC_W'(ERR_LIMIT)) err_cnt <= err_cnt + 1'b1;
        if (err_cnt == EC_W'(ERR_LIMIT - 1)) aged <= 1'b1;
      end
    end
  end

  AST_HOLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_n |=> gate_n); // R3
  AST_FAST_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_n && op_valid && !timing_err && fast) |=> gate_n); // R2
  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy && gate_n); // R4
  AST_ERR_REEXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_n && timing_err) |=> reexec && !gate_n); // R5
  AST_REEXEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reexec |=> !reexec); // R6
  AST_AGED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    aged |=> aged); // R8

endmodule

// File: tb/adaptive_hold_judge_test.sv
`timescale 1ns/1ps
module adaptive_hold_judge_test;
  localparam int OP_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [OP_W-1:0] op_data = '1;
  logic timing_err = 1'b0;
  logic gate_n, aged, reexec;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  adaptive_hold_judge uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_data(op_data),
    .timing_err(timing_err), .gate_n(gate_n), .aged(aged), .reexec(reexec)
  );

  function automatic logic [OP_W-1:0] zeros(input int k);
    return {OP_W{1'b1}} << k;
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; op_valid = 1'b0; timing_err = 1'b0;
    tick; tick;
    rst_n = 1'b1;
    chk("R1 gate_n", gate_n, 1'b1);
    chk("R1 aged", aged, 1'b0);
    chk("R1 reexec", reexec, 1'b0);
  endtask

  task automatic t_fast(input int k, input string req);
    op_valid = 1'b1; op_data = zeros(k);
    tick;
    op_valid = 1'b0;
    chk(req, gate_n, 1'b1);
    tick;
    chk(req, gate_n, 1'b1);
  endtask

  task automatic t_slow(input int k, input logic poke, input string req);
    op_valid = 1'b1; op_data = zeros(k);
    tick;
    chk(req, gate_n, 1'b0);
    op_valid = poke; op_data = zeros(0);
    tick;
    op_valid = 1'b0;
    chk("R3 release", gate_n, 1'b1);
    tick;
    chk("R4 held strobe ignored", gate_n, 1'b1);
  endtask

  task automatic t_err(input logic exp_aged, input string req);
    timing_err = 1'b1; op_valid = 1'b1; op_data = zeros(OP_W);
    tick;
    timing_err = 1'b0; op_data = zeros(0);
    chk("R5 reexec", reexec, 1'b1);
    chk("R5 gate_n", gate_n, 1'b0);
    chk(req, aged, exp_aged);
    tick;
    op_valid = 1'b0;
    chk("R6 reexec drop", reexec, 1'b0);
    chk("R6 release", gate_n, 1'b1);
    tick;
    chk("R6 strobe ignored", gate_n, 1'b1);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary;
    end
  end

  initial begin
    t_reset;
    t_fast(9, "R2 n+1 zeros fast");
    t_fast(16, "R2 all zeros fast");
    t_slow(8, 1'b0, "R7 n zeros held");
    t_slow(0, 1'b1, "R3 no zeros held");
    t_err(1'b0, "R8 one error");

    t_reset;
    t_err(1'b0, "R8 first error");
    t_err(1'b0, "R8 second error");
    for (int i = 0; i < 7; i++) t_fast(12, "R2 window fill");
    t_err(1'b1, "R8 limit reached");
    t_slow(9, 1'b0, "R9 n+1 zeros held when aged");
    t_fast(10, "R9 n+2 zeros fast when aged");
    for (int i = 0; i < 8; i++) t_fast(12, "R8 sticky");
    chk("R8 sticky", aged, 1'b1);

    t_reset;
    t_err(1'b0, "R10 err a");
    t_err(1'b0, "R10 err b");
    for (int i = 0; i < 8; i++) t_fast(12, "R10 window close");
    t_err(1'b0, "R10 new window err 1");
    t_err(1'b0, "R10 new window err 2");
    t_err(1'b1, "R10 new window err 3");
    summary;
  end
endmodule